// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from many hardware sources into one sticky 32-bit status word and condenses that word into a single interrupt line for a host processor. Each source owns a fixed bit position. A pulse on that position of the event vector latches the bit, and the bit stays set until software clears it. Software reaches three words through a plain register port. The status word is read and cleared at one offset. A write-only injection word sets status bits on demand, which is useful for testing interrupt handlers. The mask word works active-low: a bit whose mask bit is zero may raise the interrupt.

The interrupt line is a flop fed by the OR of every status bit whose mask bit is clear. It therefore follows status and mask one clock later. Two bit positions carry no source and read as zero at all times. The named sources are:
- bit 31: encoder capture start
- bit 30: encoder end of stream
- bit 27: encoder DMA done
- bit 22: decoder data request
- bit 20: decoder DMA done
- bit 18: decoder DMA list fault

Top module: `irq_agg_unit`

## Requirements
- R1: After reset the status word reads 0x0000_0000, the mask word reads 0xFFFF_FFFF and irq_out is 0.
- R2: An event_in bit that is high at a rising clock edge sets the same status bit. The bit stays set after the pulse ends, and other set bits are kept. Example positions are bit 27 (encoder DMA done), bit 20 (decoder DMA done) and bit 18 (decoder DMA list fault).
- R3: A write to offset 0x40 clears each status bit where the write data holds 1. Bits where the data holds 0 keep their value.
- R4: When an event_in bit is high in the same cycle as a clear of that bit at 0x40, the bit stays set.
- R5: A write to offset 0x44 sets each status bit where the write data holds 1. A read of 0x44 always returns 0.
- R6: Offset 0x48 holds the mask word and reads back what was last written. A status bit contributes to the interrupt only while its mask bit is 0.
- R7: Status bits 26 and 23 read as 0 whatever the events or injection writes.
- R8: irq_out is 1 exactly when, one clock earlier, some status bit was 1 with its mask bit 0.
- R9: A read of an offset other than 0x40, 0x44 or 0x48 returns 0. A write to such an offset changes neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| event_in | input | 32 | Event pulses, one bit per source |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The critical collision is a hardware event and a software clear striking the same status bit in the same clock. It is provoked by a table row that writes all ones to the status offset while an event pulse is driven on bit 22. Readback must show only bit 22 surviving. A second overlap is a clear and the registered interrupt: directed steps check that irq_out falls one cycle after the clearing edge, not on it. They also check that it rises one cycle after an unmasked event latches.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned IRQ_W  = 32;
    localparam int unsigned OFS_W  = 8;

    // Register offsets
    localparam logic [OFS_W-1:0] OFS_STATUS = 8'h40;
    localparam logic [OFS_W-1:0] OFS_INJECT = 8'h44;
    localparam logic [OFS_W-1:0] OFS_MASK   = 8'h48;

    // Event bit positions
    localparam int unsigned EV_ENC_CAP_START = 31;
    localparam int unsigned EV_ENC_EOS       = 30;
    localparam int unsigned EV_ENC_DMA_DONE  = 27;
    localparam int unsigned EV_DEC_DATA_REQ  = 22;
    localparam int unsigned EV_DEC_DMA_DONE  = 20;
    localparam int unsigned EV_DEC_LIST_ERR  = 18;

    // Positions with no source: bits 26 and 23
    localparam logic [IRQ_W-1:0] UNUSED_BITS = (IRQ_W'(1) << 26) | (IRQ_W'(1) << 23);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_INJECT,
        SEL_MASK
    } reg_sel_e;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned     W      = 32,
    parameter logic [W-1:0]    UNUSED = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] event_in,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] status_q
);

    typedef struct packed {
        logic [W-1:0] status;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first, then OR in events and injections so they win
        st_d.status = (st_q.status & ~clr_vec) | event_in | set_vec;
        st_d.status = st_d.status & ~UNUSED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q = st_q.status;

    AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|(event_in & ~UNUSED)) |=>
        ((status_q & $past(event_in & ~UNUSED)) == $past(event_in & ~UNUSED))); // R2

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(event_in & clr_vec & ~UNUSED)) |=>
        ((status_q & $past(event_in & clr_vec & ~UNUSED)) != '0)); // R4

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~event_in & ~set_vec)) |=>
        ((status_q & $past(clr_vec & ~event_in & ~set_vec)) == '0)); // R3

    AST_INJECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_vec & ~UNUSED)) |=>
        ((status_q & $past(set_vec & ~UNUSED)) == $past(set_vec & ~UNUSED))); // R5

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);

    typedef struct packed {
        logic [W-1:0] mask;
    } mreg_t;

    mreg_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr_en) begin
            m_d.mask = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{mask: '1};
        end else begin
            m_q <= m_d;
        end
    end

    assign mask_q = m_q.mask;

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mask_q == $past(wdata))); // R6

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q)); // R9

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status,
    input  logic [W-1:0] mask,
    output logic         irq_q
);

    typedef struct packed {
        logic irq;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.irq = |(status & ~mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign irq_q = o_q.irq;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & ~mask)) |=> irq_q); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~mask) == '0) |=> !irq_q); // R8

endmodule

// File: rtl/irq_agg_unit.sv
module irq_agg_unit
    import irq_agg_pkg::*;
#(
    parameter int unsigned    DATA_W = IRQ_W,
    parameter int unsigned    ADDR_W = OFS_W,
    parameter logic [ADDR_W-1:0] STATUS_OFS = OFS_STATUS,
    parameter logic [ADDR_W-1:0] INJECT_OFS = OFS_INJECT,
    parameter logic [ADDR_W-1:0] MASK_OFS   = OFS_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] event_in,
    output logic              irq_out
);

    localparam logic [DATA_W-1:0] UNUSED_MSK = DATA_W'(UNUSED_BITS);

    reg_sel_e          sel;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic              mask_wr;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] mask_w;

    always_comb begin
        if (reg_addr == STATUS_OFS) begin
            sel = SEL_STATUS;
        end else if (reg_addr == INJECT_OFS) begin
            sel = SEL_INJECT;
        end else if (reg_addr == MASK_OFS) begin
            sel = SEL_MASK;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        clr_vec = (reg_wr && sel == SEL_STATUS) ? reg_wdata : '0;
        set_vec = (reg_wr && sel == SEL_INJECT) ? reg_wdata : '0;
        mask_wr = reg_wr && (sel == SEL_MASK);
    end

    irq_status_bank #(.W(DATA_W), .UNUSED(UNUSED_MSK)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_in (event_in),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .status_q (status_w)
    );

    irq_mask_reg #(.W(DATA_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mask_wr),
        .wdata  (reg_wdata),
        .mask_q (mask_w)
    );

    irq_out_stage #(.W(DATA_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_w),
        .mask   (mask_w),
        .irq_q  (irq_out)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = status_w;
            SEL_MASK:   reg_rdata = mask_w;
            default:    reg_rdata = '0;
        endcase
    end

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_STATUS) |-> ((reg_rdata & UNUSED_MSK) == '0)); // R7

    AST_INJECT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_INJECT) |-> (reg_rdata == '0)); // R5

    AST_STRAY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (reg_rdata == '0)); // R9

    AST_STRAY_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_NONE && event_in == '0) |=> $stable(status_w)); // R9

endmodule

// File: tb/irq_agg_unit_tb.sv
module irq_agg_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] event_in = '0;
    logic        irq_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .event_in  (event_in),
        .irq_out   (irq_out)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  addr;
        logic        wr;
        logic [31:0] data;
        logic [31:0] evt;
        logic [7:0]  chk_addr;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{4'd2, 8'h00, 1'b0, 32'h0000_0000, 32'h0800_0000, 8'h40, 32'h0800_0000}, // R2 encoder DMA done
        '{4'd2, 8'h00, 1'b0, 32'h0000_0000, 32'h0014_0000, 8'h40, 32'h0814_0000}, // R2 bits 20 and 18
        '{4'd3, 8'h40, 1'b1, 32'h0800_0000, 32'h0000_0000, 8'h40, 32'h0014_0000}, // R3 clear bit 27
        '{4'd3, 8'h40, 1'b1, 32'h0000_0000, 32'h0000_0000, 8'h40, 32'h0014_0000}, // R3 zeros keep
        '{4'd5, 8'h44, 1'b1, 32'hC000_0000, 32'h0000_0000, 8'h40, 32'hC014_0000}, // R5 inject
        '{4'd7, 8'h44, 1'b1, 32'h0480_0001, 32'h0000_0000, 8'h40, 32'hC014_0001}, // R7 inject unused
        '{4'd7, 8'h00, 1'b0, 32'h0000_0000, 32'h0480_0000, 8'h40, 32'hC014_0001}, // R7 event unused
        '{4'd4, 8'h40, 1'b1, 32'hFFFF_FFFF, 32'h0040_0000, 8'h40, 32'h0040_0000}, // R4 event beats clear
        '{4'd6, 8'h48, 1'b1, 32'hFFBF_FFFF, 32'h0000_0000, 8'h48, 32'hFFBF_FFFF}, // R6 mask readback
        '{4'd9, 8'h4C, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'h40, 32'h0040_0000}, // R9 stray write
        '{4'd9, 8'h00, 1'b0, 32'h0000_0000, 32'h0000_0000, 8'h4C, 32'h0000_0000}, // R9 stray read
        '{4'd5, 8'h00, 1'b0, 32'h0000_0000, 32'h0000_0000, 8'h44, 32'h0000_0000}  // R5 inject reads zero
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: drive, cross one rising edge, release.
    task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d,
                        input logic [31:0] e);
        reg_addr  = a;
        reg_wr    = w;
        reg_wdata = d;
        event_in  = e;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
        event_in  = '0;
        reg_wdata = '0;
        reg_addr  = 8'h00;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
        reg_addr = 8'h00;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(8'h40, rv); check("R1 status after reset", rv, 32'h0);
        peek(8'h48, rv); check("R1 mask after reset", rv, 32'hFFFF_FFFF);
        check("R1 irq after reset", {31'd0, irq_out}, 32'd0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].addr, VECS[i].wr, VECS[i].data, VECS[i].evt);
            peek(VECS[i].chk_addr, rv);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), rv, VECS[i].exp);
        end

        // R6 unmasked bit 22 pending -> irq high by now
        check("R6 irq with bit 22 unmasked", {31'd0, irq_out}, 32'd1);

        // R8 timing: clean slate, mask only bit 0 enabled
        step(8'h48, 1'b1, 32'hFFFF_FFFE, 32'h0);
        step(8'h40, 1'b1, 32'hFFFF_FFFF, 32'h0);
        step(8'h00, 1'b0, 32'h0, 32'h0);
        check("R8 irq low after clear", {31'd0, irq_out}, 32'd0);
        step(8'h00, 1'b0, 32'h0, 32'h0000_0001);
        check("R8 irq not yet up at latch edge", {31'd0, irq_out}, 32'd0);
        step(8'h00, 1'b0, 32'h0, 32'h0);
        check("R8 irq up one cycle later", {31'd0, irq_out}, 32'd1);
        step(8'h40, 1'b1, 32'h0000_0001, 32'h0);
        check("R8 irq still up at clear edge", {31'd0, irq_out}, 32'd1);
        step(8'h00, 1'b0, 32'h0, 32'h0);
        check("R8 irq down one cycle after clear", {31'd0, irq_out}, 32'd0);

        // R6 masked event does not raise irq
        step(8'h00, 1'b0, 32'h0, 32'h0000_0020);
        step(8'h00, 1'b0, 32'h0, 32'h0);
        step(8'h00, 1'b0, 32'h0, 32'h0);
        peek(8'h40, rv); check("R6 masked bit latched", rv, 32'h0000_0020);
        check("R6 masked bit gives no irq", {31'd0, irq_out}, 32'd0);

        // R9 stray write leaves mask
        step(8'h50, 1'b1, 32'h0, 32'h0);
        peek(8'h48, rv); check("R9 mask kept after stray write", rv, 32'hFFFF_FFFE);

        // R2 sticky across several bits
        step(8'h00, 1'b0, 32'h0, 32'hC000_0000);
        step(8'h00, 1'b0, 32'h0, 32'h0);
        peek(8'h40, rv); check("R2 capture start and eos sticky", rv, 32'hC000_0020);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule